// File: doc/BRIEF.md
# Multi-Channel General-Purpose Timer Bank

This block holds a bank of identical up-counting timer channels behind one 32-bit register bus. Each channel counts steps of a chosen tick source, optionally halved, and compares its count with a programmed value. Depending on its operating mode, a channel stops after one match, restarts after every match, or runs freely without ever matching. A matching channel sets its bit in a shared pending register. A shared enable register decides which pending bits drive the single combined interrupt line. Software clears pending bits by writing ones to the acknowledge register.

The block receives no clocks of its own beyond the bus clock. Each tick source arrives as a one-cycle enable pulse, so a slow real-time source and the fast system source both run in the same clock domain. Channels are numbered from 1. Channel n's four registers start at byte offset 16·n, and the shared registers sit in the otherwise unused window at offset 0.

Top module: `tmr_bank`

## Requirements
- R1: Channel n (1..NUM_CH) decodes four word registers: control at 16·n, clock select at 16·n+4, count at 16·n+8, compare at 16·n+12. The compare register reads back all 32 bits as written. Clock select keeps only bit 4 (source) and bit 0 (divider) and reads every other bit as 0.
- R2: After reset every register reads 0, no channel counts, and irq is 0.
- R3: Offset 0x08 is the acknowledge register, with channel n at bit n-1. Writing a 1 to a bit clears that pending bit, and writing a 0 leaves it unchanged. A read of 0x08 returns the pending bits. A match in the same cycle as the acknowledge wins.
- R4: Mode 0 (one-shot, control bits 5:4 = 0): a step that brings the count to the compare value sets the pending bit, leaves the count at the compare value, and clears the enable bit (control bit 0).
- R5: Mode 1 (repeat): a step that brings the count to the compare value sets the pending bit and sets the count to 0, and the channel stays enabled.
- R6: Modes 3 (free-run) and 2 count every step, wrap at 2^32 and never set a pending bit.
- R7: The enable register at offset 0x00 holds one bit per channel, at bit n-1. irq is a register equal, one cycle later, to the OR over channels of (pending AND enabled). A pending bit is set whether or not its enable bit is 1.
- R8: Writing control with bit 1 set makes the count 0 after that clock edge. Bit 1 reads back as 0.
- R9: While control bit 0 is 0 the count does not change. Compare and mode stay writable while the channel is disabled.
- R10: Clock select bit 4 picks the tick source (0 = tick_fast, 1 = tick_slow). Ticks of the other source are ignored. Bit 0 = 1 makes the channel step on every second tick of the selected source, starting with the second tick after a clear or a clock-select write.
- R11: The count register is read-only. Writes to it have no effect.
- R12: bus_rdata is loaded on the clock edge where bus_rd is 1 and holds otherwise. Unmapped or unaligned addresses read as 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and timer clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_fast | input | 1 | One-cycle tick pulse of the fast source |
| tick_slow | input | 1 | One-cycle tick pulse of the slow source |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| irq | output | 1 | Combined registered interrupt |

## Verification
A tick sampled at a clock edge updates the count and the pending bit at that same edge. irq follows one edge later, and a read issued in the next cycle returns the new value one edge after the strobe. The bench drives every stimulus on a falling edge and lets the task return only after the effective rising edge. It reads results through bus reads that capture bus_rdata on the falling edge after the strobe. For irq it waits one extra falling edge after the register write that should change it. Random trials pick a channel, mode, compare value and tick count. Expected count, enable and pending values come from a step-by-step bench model.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    MODE_ONCE = 2'd0,
    MODE_LOOP = 2'd1,
    MODE_RSVD = 2'd2,
    MODE_FREE = 2'd3
  } tmr_mode_e;

  // word select inside a channel's 16-byte window
  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_CSEL = 2'd1;
  localparam logic [1:0] SEL_CNT  = 2'd2;
  localparam logic [1:0] SEL_CMP  = 2'd3;

  // word select inside the shared window at offset 0
  localparam logic [1:0] SEL_IEN  = 2'd0;
  localparam logic [1:0] SEL_ACK  = 2'd2;

  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_CLR_BIT  = 1;
  localparam int CTRL_MODE_LSB = 4;
  localparam int CSEL_DIV_BIT  = 0;
  localparam int CSEL_SRC_BIT  = 4;
endpackage

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen (
  input  logic clk,
  input  logic rst,
  input  logic tick_fast,
  input  logic tick_slow,
  input  logic src_sel,
  input  logic div2,
  input  logic run,
  input  logic restart,
  output logic step
);
  logic src_tick;
  logic phase_q;

  assign src_tick = src_sel ? tick_slow : tick_fast;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      phase_q <= 1'b0;
    end else if (run && src_tick && div2) begin
      phase_q <= ~phase_q;
    end
  end

  assign step = run && src_tick && (!div2 || phase_q);
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_fast,
  input  logic              tick_slow,
  input  logic              wr_ctrl,
  input  logic              wr_csel,
  input  logic              wr_cmp,
  input  logic              ctrl_en_in,
  input  logic              ctrl_clr_in,
  input  logic [1:0]        ctrl_mode_in,
  input  logic              csel_src_in,
  input  logic              csel_div_in,
  input  logic [DATA_W-1:0] cmp_in,
  output logic              en,
  output tmr_mode_e         mode,
  output logic              src_sel,
  output logic              div2,
  output logic [DATA_W-1:0] cnt,
  output logic [DATA_W-1:0] cmp,
  output logic              evt,
  output logic              clr_req
);
  logic              step;
  logic [DATA_W-1:0] cnt_inc;
  logic              matching_mode;

  assign clr_req       = wr_ctrl && ctrl_clr_in;
  assign cnt_inc       = cnt + 1'b1;
  assign matching_mode = (mode == MODE_ONCE) || (mode == MODE_LOOP);
  assign evt           = step && !clr_req && matching_mode && (cnt_inc == cmp);

  tmr_tick_gen i_tick (
    .clk       (clk),
    .rst       (rst),
    .tick_fast (tick_fast),
    .tick_slow (tick_slow),
    .src_sel   (src_sel),
    .div2      (div2),
    .run       (en),
    .restart   (clr_req || wr_csel),
    .step      (step)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      en   <= 1'b0;
      mode <= MODE_ONCE;
    end else if (wr_ctrl) begin
      en   <= ctrl_en_in;
      mode <= tmr_mode_e'(ctrl_mode_in);
    end else if (evt && mode == MODE_ONCE) begin
      en   <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      src_sel <= 1'b0;
      div2    <= 1'b0;
    end else if (wr_csel) begin
      src_sel <= csel_src_in;
      div2    <= csel_div_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp <= '0;
    end else if (wr_cmp) begin
      cmp <= cmp_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr_req) begin
      cnt <= '0;
    end else if (step) begin
      if (evt && mode == MODE_LOOP) begin
        cnt <= '0;
      end else begin
        cnt <= cnt_inc;
      end
    end
  end
endmodule

// File: rtl/tmr_irq_ctrl.sv
module tmr_irq_ctrl #(
  parameter int NUM_CH = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_ien,
  input  logic              wr_ack,
  input  logic [NUM_CH-1:0] wbits,
  input  logic [NUM_CH-1:0] evt,
  output logic [NUM_CH-1:0] ien,
  output logic [NUM_CH-1:0] pend,
  output logic [NUM_CH-1:0] ack_mask,
  output logic              irq
);
  assign ack_mask = wr_ack ? wbits : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      ien <= '0;
    end else if (wr_ien) begin
      ien <= wbits;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= '0;
    end else begin
      pend <= (pend & ~ack_mask) | evt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq <= 1'b0;
    end else begin
      irq <= |(pend & ien);
    end
  end
endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
  import tmr_pkg::*;
#(
  parameter int NUM_CH = 6,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_fast,
  input  logic              tick_slow,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  localparam int IDX_W = ADDR_W - 4;

  logic [IDX_W-1:0] idx;
  logic [1:0]       sel;
  logic             aligned;
  logic             shared_hit;
  logic             wr_ien;
  logic             wr_ack;

  assign idx        = bus_addr[ADDR_W-1:4];
  assign sel        = bus_addr[3:2];
  assign aligned    = (bus_addr[1:0] == 2'b00);
  assign shared_hit = aligned && (idx == '0);
  assign wr_ien     = bus_wr && shared_hit && (sel == SEL_IEN);
  assign wr_ack     = bus_wr && shared_hit && (sel == SEL_ACK);

  logic              en_a   [NUM_CH];
  tmr_mode_e         mode_a [NUM_CH];
  logic              src_a  [NUM_CH];
  logic              div_a  [NUM_CH];
  logic [DATA_W-1:0] cnt_a  [NUM_CH];
  logic [DATA_W-1:0] cmp_a  [NUM_CH];

  logic [NUM_CH-1:0]        evt_v;
  logic [NUM_CH-1:0]        en_v;
  logic [NUM_CH-1:0]        clr_v;
  logic [NUM_CH-1:0]        wrc_v;
  logic [2*NUM_CH-1:0]      mode_v;
  logic [DATA_W*NUM_CH-1:0] cnt_v;
  logic [NUM_CH-1:0]        ien_q;
  logic [NUM_CH-1:0]        pend_q;
  logic [NUM_CH-1:0]        ack_v;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic hit;
    assign hit = aligned && (idx == IDX_W'(i + 1));
    assign wrc_v[i] = bus_wr && hit && (sel == SEL_CTRL);

    tmr_channel #(.DATA_W(DATA_W)) i_chan (
      .clk          (clk),
      .rst          (rst),
      .tick_fast    (tick_fast),
      .tick_slow    (tick_slow),
      .wr_ctrl      (wrc_v[i]),
      .wr_csel      (bus_wr && hit && (sel == SEL_CSEL)),
      .wr_cmp       (bus_wr && hit && (sel == SEL_CMP)),
      .ctrl_en_in   (bus_wdata[CTRL_EN_BIT]),
      .ctrl_clr_in  (bus_wdata[CTRL_CLR_BIT]),
      .ctrl_mode_in (bus_wdata[CTRL_MODE_LSB +: 2]),
      .csel_src_in  (bus_wdata[CSEL_SRC_BIT]),
      .csel_div_in  (bus_wdata[CSEL_DIV_BIT]),
      .cmp_in       (bus_wdata),
      .en           (en_a[i]),
      .mode         (mode_a[i]),
      .src_sel      (src_a[i]),
      .div2         (div_a[i]),
      .cnt          (cnt_a[i]),
      .cmp          (cmp_a[i]),
      .evt          (evt_v[i]),
      .clr_req      (clr_v[i])
    );

    assign en_v[i]                  = en_a[i];
    assign mode_v[2*i +: 2]         = mode_a[i];
    assign cnt_v[DATA_W*i +: DATA_W] = cnt_a[i];
  end

  tmr_irq_ctrl #(.NUM_CH(NUM_CH)) i_irq (
    .clk      (clk),
    .rst      (rst),
    .wr_ien   (wr_ien),
    .wr_ack   (wr_ack),
    .wbits    (bus_wdata[NUM_CH-1:0]),
    .evt      (evt_v),
    .ien      (ien_q),
    .pend     (pend_q),
    .ack_mask (ack_v),
    .irq      (irq)
  );

  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    if (shared_hit) begin
      if (sel == SEL_IEN) rd_mux[NUM_CH-1:0] = ien_q;
      if (sel == SEL_ACK) rd_mux[NUM_CH-1:0] = pend_q;
    end
    for (int i = 0; i < NUM_CH; i++) begin
      if (aligned && idx == IDX_W'(i + 1)) begin
        case (sel)
          SEL_CTRL: begin
            rd_mux[CTRL_EN_BIT]        = en_a[i];
            rd_mux[CTRL_MODE_LSB +: 2] = mode_a[i];
          end
          SEL_CSEL: begin
            rd_mux[CSEL_SRC_BIT] = src_a[i];
            rd_mux[CSEL_DIV_BIT] = div_a[i];
          end
          SEL_CNT: rd_mux = cnt_a[i];
          default: rd_mux = cmp_a[i];
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      bus_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/tmr_bank_chk.sv
module tmr_bank_chk #(
  parameter int NUM_CH = 6,
  parameter int DATA_W = 32
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     irq,
  input logic [NUM_CH-1:0]        pend,
  input logic [NUM_CH-1:0]        ien,
  input logic [NUM_CH-1:0]        evt,
  input logic [NUM_CH-1:0]        en,
  input logic [NUM_CH-1:0]        clr,
  input logic [NUM_CH-1:0]        wrc,
  input logic [NUM_CH-1:0]        ack,
  input logic [2*NUM_CH-1:0]      mode,
  input logic [DATA_W*NUM_CH-1:0] cnt
);
  // R7: combined line follows enabled pending bits one cycle later
  p_irq_tracks_r7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == $past(|(pend & ien))));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    p_pend_sets_r7: assert property (@(posedge clk) disable iff (rst)
      evt[i] |=> pend[i]);

    p_ack_clears_r3: assert property (@(posedge clk) disable iff (rst)
      (ack[i] && !evt[i]) |=> !pend[i]);

    p_oneshot_stop_r4: assert property (@(posedge clk) disable iff (rst)
      (evt[i] && mode[2*i +: 2] == 2'd0 && !wrc[i]) |=> !en[i]);

    p_loop_restart_r5: assert property (@(posedge clk) disable iff (rst)
      (evt[i] && mode[2*i +: 2] == 2'd1) |=> (cnt[DATA_W*i +: DATA_W] == '0));

    p_freerun_quiet_r6: assert property (@(posedge clk) disable iff (rst)
      (mode[2*i +: 2] == 2'd3) |-> !evt[i]);

    p_clear_zero_r8: assert property (@(posedge clk) disable iff (rst)
      clr[i] |=> (cnt[DATA_W*i +: DATA_W] == '0));

    p_frozen_r9: assert property (@(posedge clk) disable iff (rst)
      (!en[i] && !clr[i]) |=> $stable(cnt[DATA_W*i +: DATA_W]));
  end
endmodule

bind tmr_bank tmr_bank_chk #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) i_chk (
  .clk  (clk),
  .rst  (rst),
  .irq  (irq),
  .pend (pend_q),
  .ien  (ien_q),
  .evt  (evt_v),
  .en   (en_v),
  .clr  (clr_v),
  .wrc  (wrc_v),
  .ack  (ack_v),
  .mode (mode_v),
  .cnt  (cnt_v)
);

// File: tb/test_tmr_bank.sv
module test_tmr_bank;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_fast = 1'b0;
  logic        tick_slow = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  tmr_bank i_tmr_bank (
    .clk(clk), .rst(rst), .tick_fast(tick_fast), .tick_slow(tick_slow),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic give_ticks(input bit slow, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (slow) tick_slow = 1'b1; else tick_fast = 1'b1;
    end
    @(negedge clk);
    tick_fast = 1'b0; tick_slow = 1'b0;
  endtask

  function automatic logic [7:0] a_ctrl(input int ch); return 8'(ch * 16);      endfunction
  function automatic logic [7:0] a_csel(input int ch); return 8'(ch * 16 + 4);  endfunction
  function automatic logic [7:0] a_cnt (input int ch); return 8'(ch * 16 + 8);  endfunction
  function automatic logic [7:0] a_cmp (input int ch); return 8'(ch * 16 + 12); endfunction

  // step-by-step model of one channel stepping on every tick
  function automatic void model(input int mode, input int cmp, input int n,
                                output int cnt, output bit en, output bit pend);
    cnt = 0; en = 1'b1; pend = 1'b0;
    for (int k = 0; k < n; k++) begin
      if (en) begin
        int nx;
        nx = cnt + 1;
        if ((mode == 0 || mode == 1) && nx == cmp) begin
          pend = 1'b1;
          if (mode == 0) begin cnt = nx; en = 1'b0; end
          else cnt = 0;
        end else begin
          cnt = nx;
        end
      end
    end
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired, all requirements actual=hung expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int seed_val;
    seed_val = $urandom(32'h5EED_0042);
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R2 reset state
    rd(8'h00, d); check("R2 ien after reset", d, 0);
    rd(8'h08, d); check("R2 pending after reset", d, 0);
    rd(a_ctrl(1), d); check("R2 ctrl after reset", d, 0);
    rd(a_cnt(3), d); check("R2 count after reset", d, 0);
    check("R2 irq after reset", {31'b0, irq}, 0);

    // R1 map and readback
    wr(a_cmp(3), 32'hA5A5_1234); rd(a_cmp(3), d); check("R1 compare readback", d, 32'hA5A5_1234);
    wr(a_csel(3), 32'hFFFF_FFFF); rd(a_csel(3), d); check("R1 csel keeps bits 4,0", d, 32'h11);
    wr(a_csel(3), 32'h0);

    // R12 unmapped and unaligned
    rd(8'h04, d); check("R12 unmapped 0x04", d, 0);
    rd(8'h70, d); check("R12 channel beyond range", d, 0);
    wr(8'h3D, 32'h1); rd(a_cmp(3), d); check("R12 unaligned write ignored", d, 32'hA5A5_1234);

    // R11 count read-only
    wr(a_cnt(3), 32'h55); rd(a_cnt(3), d); check("R11 count write ignored", d, 0);

    // R6 free-run on channel 2
    wr(a_cmp(2), 10); wr(a_ctrl(2), 32'h31);
    give_ticks(0, 10);
    rd(a_cnt(2), d); check("R6 free-run count", d, 10);
    rd(8'h08, d); check("R6 free-run no pending", d, 0);
    give_ticks(0, 5);
    rd(a_cnt(2), d); check("R6 free-run continues", d, 15);

    // R9 disable freezes; compare writable
    wr(a_ctrl(2), 32'h30);
    give_ticks(0, 4);
    rd(a_cnt(2), d); check("R9 frozen count", d, 15);
    wr(a_cmp(2), 7); rd(a_cmp(2), d); check("R9 compare writable while off", d, 7);

    // R8 clear
    wr(a_ctrl(2), 32'h32);
    rd(a_cnt(2), d); check("R8 clear zeroes count", d, 0);
    rd(a_ctrl(2), d); check("R8 clear bit reads 0", d, 32'h30);

    // R10 divider and source select on channel 4
    wr(a_csel(4), 32'h01); wr(a_ctrl(4), 32'h33);
    give_ticks(0, 9);
    rd(a_cnt(4), d); check("R10 divide by two", d, 4);
    wr(a_csel(4), 32'h10);
    give_ticks(0, 5);
    rd(a_cnt(4), d); check("R10 other source ignored", d, 4);
    give_ticks(1, 3);
    rd(a_cnt(4), d); check("R10 slow source counts", d, 7);
    wr(a_ctrl(4), 32'h30);

    // R4 one-shot on channel 1, interrupt masked
    wr(a_cmp(1), 5); wr(a_ctrl(1), 32'h03);
    give_ticks(0, 5);
    rd(a_cnt(1), d); check("R4 one-shot count holds at compare", d, 5);
    rd(a_ctrl(1), d); check("R4 one-shot clears enable", d, 0);
    rd(8'h08, d); check("R4 one-shot pending", d, 32'h01);
    check("R7 masked pending gives no irq", {31'b0, irq}, 0);
    give_ticks(0, 3);
    rd(a_cnt(1), d); check("R4 no counting after one-shot", d, 5);

    // R7 enabling the bit raises irq
    wr(8'h00, 32'h01);
    @(negedge clk);
    check("R7 irq after enable", {31'b0, irq}, 1);

    // R3 acknowledge
    wr(8'h08, 32'h01);
    @(negedge clk);
    check("R3 irq drops after ack", {31'b0, irq}, 0);
    rd(8'h08, d); check("R3 pending cleared", d, 0);

    // R5 repeat on channel 6
    wr(a_cmp(6), 3); wr(a_ctrl(6), 32'h13);
    give_ticks(0, 7);
    rd(a_cnt(6), d); check("R5 repeat restart count", d, 1);
    rd(a_ctrl(6), d); check("R5 repeat stays enabled", d, 32'h11);
    wr(8'h08, 32'h01);
    rd(8'h08, d); check("R3 zero bits leave pending", d, 32'h20);
    wr(8'h08, 32'h3F);
    rd(8'h08, d); check("R3 ack all", d, 0);
    wr(a_ctrl(6), 32'h10);

    // random trials
    for (int t = 0; t < 30; t++) begin
      int ch, mi, mode, cmp, n, ecnt;
      bit een, epend;
      ch   = 1 + int'($urandom % 6);
      mi   = int'($urandom % 3);
      mode = (mi == 2) ? 3 : mi;
      cmp  = 2 + int'($urandom % 14);
      n    = 1 + int'($urandom % 40);
      model(mode, cmp, n, ecnt, een, epend);
      wr(a_ctrl(ch), 32'((mode << 4) | 2));
      wr(a_csel(ch), 0);
      wr(a_cmp(ch), 32'(cmp));
      wr(8'h08, 32'h3F);
      wr(a_ctrl(ch), 32'((mode << 4) | 1));
      give_ticks(0, n);
      rd(a_cnt(ch), d);
      check(mode == 0 ? "R4 random count" : (mode == 1 ? "R5 random count" : "R6 random count"),
            d, 32'(ecnt));
      rd(a_ctrl(ch), d); check("R4 random enable", d, 32'((mode << 4) | int'(een)));
      rd(8'h08, d); check("R3 random pending", d, 32'(int'(epend) << (ch - 1)));
      wr(a_ctrl(ch), 32'(mode << 4));
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule